// File: doc/BRIEF.md
# Per-Bit Fan-Out Interrupt Group

This block collects 32 level source lines into one interrupt group and gives each of its ten low status bits its own interrupt output line. In any cycle, a source line that is high and enabled is a capture event for its bit. Bit i either latches into status and raises output line i, or, if that bit is busy (its status bit is already set, or its mask bit is set), is deferred into a pending bit. Software acknowledges work by writing ones to the status register. Each acknowledged bit then either replays its deferred event or drops its output line, independently of the other nine bits.

The enable register has two roles. A write that adds enable bits accumulates them into the enable set. A write that adds no new bit is read as a mask or unmask operation: the bits that differ from the last written value are masked or unmasked, depending on whether the new value raises or lowers them. Register access is a single 32-bit write port with a one-bit register select, and a combinational read port with its own select.

Top module: `fanout_intc`

## Requirements
- R1: After reset, both readable registers read zero, irqOut is zero, and the enable set, mask and pending state are empty.
- R2: A capture on bit i (i below 10), with mask bit i and status bit i both clear, sets status bit i and drives irqOut[i] high on the next clock edge.
- R3: A capture on bit i while mask bit i or status bit i is set leaves status unchanged and sets pending bit i.
- R4: An enable write (wrAddr = 0) whose data adds bits not yet in the enable set ORs them into the set and stores the data. A zero write while the set is empty stores zero. Enable bits are never removed.
- R5: An enable write that adds no new bit compares the data with the stored value. If some differing bit is set in the data, all differing bits are unmasked. Otherwise the differing bits are masked. The data is then stored.
- R6: A status write (wrAddr = 1) of zero changes nothing.
- R7: A nonzero status write clears the written status bits. Then, for each written bit i below 10 that has pending bit i set, status bit i is set again, pending bit i is cleared, and irqOut[i] is driven high.
- R8: For each written bit i below 10 with no pending event, a nonzero status write drives irqOut[i] low.
- R9: A status write of 0xFFFFFFFF clears all status bits, but leaves pending and irqOut unchanged.
- R10: Source lines whose enable bit is clear have no effect on status, pending or irqOut.
- R11: Status bits 10 to 31 always read zero, and captures on source lines 10 to 31 have no effect on status or irqOut.
- R12: Reading with rdAddr = 0 returns the last value written to the enable register, and reading with rdAddr = 1 returns status.
- R13: In a cycle with both a status write and a capture, the write is applied first, and the capture then sees the updated status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Source interrupt lines, sampled every cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write select: 0 enable register, 1 status register |
| wrData | input | 32 | Write data |
| rdAddr | input | 1 | Read select: 0 enable register, 1 status register |
| rdData | output | 32 | Read data for the selected register |
| irqOut | output | 10 | One registered interrupt line per low status bit |

## Verification
The bound checker covers the per-bit rules on every cycle:
- capture into an idle bit raises its status bit and its line;
- a busy bit defers its event into pending;
- disabled sources and zero status writes leave every bit alone;
- the all-ones status write keeps every line steady;
- the enable set only grows.

Only the bench scenarios can show the enable and mask decision, because it depends on the history of written values. The same holds for replay of a deferred event after an acknowledge, for a pending event surviving an all-ones clear, and for the order in which a write and a capture in the same cycle are applied. Those scenarios compare against a model kept in the bench.

// File: rtl/fanout_intc_pkg.sv
package fanout_intc_pkg;
  // Strobes from the register control to the per-bit datapath
  typedef struct packed {
    logic enableWr;   // enable register written this cycle
    logic statusWr;   // nonzero status write: clear written bits
    logic replay;     // status write that also runs per-bit follow-up
  } regStrobe_t;
endpackage

// File: rtl/fanout_intc_ctrl.sv
module fanout_intc_ctrl
  import fanout_intc_pkg::*;
#(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [SRC_W-1:0] wrData,
  output regStrobe_t       strobe,
  output logic [SRC_W-1:0] enableAcc,
  output logic [SRC_W-1:0] maskBits,
  output logic [SRC_W-1:0] enableShadow
);
  localparam logic [SRC_W-1:0] ALL_ONES = '1;

  logic [SRC_W-1:0] grownAcc;
  logic [SRC_W-1:0] diffBits;
  logic             statusHit;

  assign statusHit = wrEn && wrAddr && (wrData != '0);

  always_comb begin
    strobe          = '0;
    strobe.enableWr = wrEn && !wrAddr;
    strobe.statusWr = statusHit;
    strobe.replay   = statusHit && (wrData != ALL_ONES);
  end

  assign grownAcc = enableAcc | wrData;
  assign diffBits = enableShadow ^ wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableAcc    <= '0;
      maskBits     <= '0;
      enableShadow <= '0;
    end else if (strobe.enableWr) begin
      if (wrData == '0 && enableAcc == '0) begin
        enableShadow <= '0;
      end else if (grownAcc != enableAcc) begin
        enableAcc    <= grownAcc;
        enableShadow <= wrData;
      end else begin
        if ((diffBits & wrData) != '0) maskBits <= maskBits & ~diffBits;
        else                           maskBits <= maskBits | diffBits;
        enableShadow <= wrData;
      end
    end
  end
endmodule

// File: rtl/fanout_intc_slice.sv
module fanout_intc_slice (
  input  logic clk,
  input  logic rstN,
  input  logic selBit,
  input  logic maskBit,
  input  logic clrBit,
  input  logic replayBit,
  output logic statusQ,
  output logic pendingQ,
  output logic lineQ
);
  logic stMid, pdMid, lnMid;
  logic stNext, pdNext, lnNext;

  // status write first
  always_comb begin
    stMid = statusQ & ~clrBit;
    pdMid = pendingQ;
    lnMid = lineQ;
    if (replayBit) begin
      if (pendingQ) begin
        stMid = 1'b1;
        pdMid = 1'b0;
        lnMid = 1'b1;
      end else begin
        lnMid = 1'b0;
      end
    end
  end

  // capture sees post-write status
  always_comb begin
    stNext = stMid;
    pdNext = pdMid;
    lnNext = lnMid;
    if (selBit) begin
      if (maskBit || stMid) begin
        pdNext = 1'b1;
      end else begin
        stNext = 1'b1;
        lnNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= 1'b0;
      pendingQ <= 1'b0;
      lineQ    <= 1'b0;
    end else begin
      statusQ  <= stNext;
      pendingQ <= pdNext;
      lineQ    <= lnNext;
    end
  end
endmodule

// File: rtl/fanout_intc_datapath.sv
module fanout_intc_datapath
  import fanout_intc_pkg::*;
#(
  parameter int NUM_OUT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [NUM_OUT-1:0] selVec,
  input  logic [NUM_OUT-1:0] maskVec,
  input  logic [NUM_OUT-1:0] wrLow,
  output logic [NUM_OUT-1:0] statusBits,
  output logic [NUM_OUT-1:0] pendingBits,
  output logic [NUM_OUT-1:0] irqOut
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    fanout_intc_slice u_slice (
      .clk      (clk),
      .rstN     (rstN),
      .selBit   (selVec[i]),
      .maskBit  (maskVec[i]),
      .clrBit   (strobe.statusWr && wrLow[i]),
      .replayBit(strobe.replay && wrLow[i]),
      .statusQ  (statusBits[i]),
      .pendingQ (pendingBits[i]),
      .lineQ    (irqOut[i])
    );
  end
endmodule

// File: rtl/fanout_intc.sv
module fanout_intc
  import fanout_intc_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int NUM_OUT = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_W-1:0]   srcIn,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [SRC_W-1:0]   wrData,
  input  logic               rdAddr,
  output logic [SRC_W-1:0]   rdData,
  output logic [NUM_OUT-1:0] irqOut
);
  regStrobe_t         strobe;
  logic [SRC_W-1:0]   enableAcc;
  logic [SRC_W-1:0]   maskBits;
  logic [SRC_W-1:0]   enableShadow;
  logic [NUM_OUT-1:0] statusBits;
  logic [NUM_OUT-1:0] pendingBits;
  logic [NUM_OUT-1:0] selVec;
  logic [SRC_W-1:0]   statusWide;

  fanout_intc_ctrl #(.SRC_W(SRC_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .strobe      (strobe),
    .enableAcc   (enableAcc),
    .maskBits    (maskBits),
    .enableShadow(enableShadow)
  );

  assign selVec = srcIn[NUM_OUT-1:0] & enableAcc[NUM_OUT-1:0];

  fanout_intc_datapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .selVec     (selVec),
    .maskVec    (maskBits[NUM_OUT-1:0]),
    .wrLow      (wrData[NUM_OUT-1:0]),
    .statusBits (statusBits),
    .pendingBits(pendingBits),
    .irqOut     (irqOut)
  );

  always_comb begin
    statusWide              = '0;
    statusWide[NUM_OUT-1:0] = statusBits;
  end

  assign rdData = rdAddr ? statusWide : enableShadow;
endmodule

// File: rtl/fanout_intc_chk.sv
module fanout_intc_chk #(
  parameter int SRC_W   = 32,
  parameter int NUM_OUT = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic [SRC_W-1:0]   srcIn,
  input logic               wrEn,
  input logic               wrAddr,
  input logic [SRC_W-1:0]   wrData,
  input logic [NUM_OUT-1:0] irqOut,
  input logic [SRC_W-1:0]   enableAcc,
  input logic [SRC_W-1:0]   maskBits,
  input logic [NUM_OUT-1:0] statusBits,
  input logic [NUM_OUT-1:0] pendingBits
);
  logic statusWrite;
  logic noCapture;
  assign statusWrite = wrEn && wrAddr;
  assign noCapture   = (srcIn[NUM_OUT-1:0] & enableAcc[NUM_OUT-1:0]) == '0;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bitChk
    assert_capture_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      (srcIn[i] && enableAcc[i] && !maskBits[i] && !statusBits[i] && !statusWrite)
      |=> (statusBits[i] && irqOut[i]));

    assert_defer_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
      (srcIn[i] && enableAcc[i] && (maskBits[i] || statusBits[i]) && !statusWrite)
      |=> (pendingBits[i] && $stable(statusBits[i])));
  end

  assert_enable_grows_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((enableAcc & $past(enableAcc)) == $past(enableAcc)));

  assert_zero_status_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && wrData == '0 && noCapture)
    |=> ($stable(statusBits) && $stable(pendingBits) && $stable(irqOut)));

  assert_clear_all_keeps_lines_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && (&wrData) && noCapture)
    |=> (statusBits == '0 && $stable(pendingBits) && $stable(irqOut)));

  assert_disabled_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && noCapture)
    |=> ($stable(statusBits) && $stable(pendingBits) && $stable(irqOut)));
endmodule

bind fanout_intc fanout_intc_chk #(.SRC_W(SRC_W), .NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcIn      (srcIn),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .irqOut     (irqOut),
  .enableAcc  (enableAcc),
  .maskBits   (maskBits),
  .statusBits (statusBits),
  .pendingBits(pendingBits)
);

// File: tb/fanout_intc_tb.sv
module fanout_intc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdAddr = 1'b0;
  logic [31:0] rdData;
  logic [9:0]  irqOut;

  fanout_intc u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench-side model state
  logic [31:0] mAcc, mReg, mMask;
  logic [9:0]  mStat, mPend, mOut;

  task automatic modelStep(input logic [31:0] s, input logic we,
                           input logic a, input logic [31:0] d);
    logic [31:0] oldAcc, oldMask, nacc, chg;
    oldAcc = mAcc;
    oldMask = mMask;
    if (we && !a) begin
      if (d == 0 && mAcc == 0) mReg = 0;
      else begin
        nacc = mAcc | d;
        if (nacc != mAcc) begin mAcc = nacc; mReg = d; end
        else begin
          chg = mReg ^ d;
          if ((chg & d) != 0) mMask = mMask & ~chg;
          else mMask = mMask | chg;
          mReg = d;
        end
      end
    end
    if (we && a && d != 0) begin
      mStat = mStat & ~d[9:0];
      if (d != 32'hFFFF_FFFF) begin
        for (int i = 0; i < NB; i++) begin
          if (d[i]) begin
            if (mPend[i]) begin mStat[i] = 1; mPend[i] = 0; mOut[i] = 1; end
            else mOut[i] = 0;
          end
        end
      end
    end
    for (int i = 0; i < NB; i++) begin
      if (s[i] && oldAcc[i]) begin
        if (oldMask[i] || mStat[i]) mPend[i] = 1;
        else begin mStat[i] = 1; mOut[i] = 1; end
      end
    end
  endtask

  task automatic check1(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    rdAddr = 1'b0; #1;
    check1(req, "enable read", rdData, mReg);
    rdAddr = 1'b1; #1;
    check1(req, "status read", rdData, {22'd0, mStat});
    check1(req, "irq lines", {22'd0, irqOut}, {22'd0, mOut});
  endtask

  // one clock with the given stimulus, then compare
  task automatic step(input logic [31:0] s, input logic we, input logic a,
                      input logic [31:0] d, input string req);
    @(negedge clk);
    srcIn = s; wrEn = we; wrAddr = a; wrData = d;
    @(posedge clk);
    modelStep(s, we, a, d);
    #1;
    srcIn = '0; wrEn = 0; wrAddr = 0; wrData = '0;
    checkAll(req);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    mAcc = 0; mReg = 0; mMask = 0; mStat = 0; mPend = 0; mOut = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    checkAll("R1");

    // R10: sources with nothing enabled
    step(32'hFFFF_FFFF, 0, 0, 0, "R10");
    // R4: zero write on empty set, then grow set
    step(0, 1, 0, 32'h0, "R4");
    step(0, 1, 0, 32'h0000_00FF, "R4");
    step(32'h0000_0300, 0, 0, 0, "R10");
    step(0, 1, 0, 32'hFFFF_FFFF, "R12");

    // R2, R8, R11: capture each bit then acknowledge it
    for (int i = 0; i < 32; i++) begin
      step(32'h1 << i, 0, 0, 0, (i < NB) ? "R2" : "R11");
      step(0, 1, 1, 32'h1 << i, "R8");
    end

    // R3, R7: second capture defers, acknowledge replays
    for (int i = 0; i < NB; i++) begin
      step(32'h1 << i, 0, 0, 0, "R2");
      step(32'h1 << i, 0, 0, 0, "R3");
      step(0, 1, 1, 32'h1 << i, "R7");
      step(0, 1, 1, 32'h1 << i, "R8");
    end

    // R5: mask bit 0 then unmask it
    step(0, 1, 0, 32'hFFFF_FFFE, "R5");
    step(32'h1, 0, 0, 0, "R5");
    step(0, 1, 0, 32'hFFFF_FFFF, "R5");
    step(0, 1, 1, 32'h1, "R7");
    step(0, 1, 1, 32'h1, "R8");

    // R6: zero status write
    step(32'h0000_0155, 0, 0, 0, "R2");
    step(0, 1, 1, 32'h0, "R6");

    // R9: pending survives a full clear, lines steady
    step(32'h0000_03FF, 0, 0, 0, "R3");
    step(0, 1, 1, 32'hFFFF_FFFF, "R9");
    step(0, 1, 1, 32'h0000_0004, "R7");
    step(0, 1, 1, 32'h0000_03FF, "R8");

    // R13: write and capture in the same cycle
    step(32'h2, 0, 0, 0, "R2");
    step(32'h2, 1, 1, 32'h2, "R13");
    step(32'h2, 1, 1, 32'h2, "R13");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, d;
      r = $urandom;
      d = $urandom;
      if (r[3:2] == 2'b00) d = {22'd0, d[9:0]} & (32'h1 << r[7:4]);
      if (r[9:8] == 2'b11 && r[10]) d = 32'hFFFF_FFFF;
      step({$urandom} & 32'h0000_0FFF & (r[11] ? 32'hFFFF_FFFF : 32'h0),
           r[0], r[1] | r[12], d, "R2 R3 R5 R7 R8");
    end

    finish();
  end
endmodule